// File: doc/BRIEF.md
# Mode-Selectable Array Multiplier

This block multiplies two operands of equal width and returns a product twice as wide. A single mode pin decides how both operands are read. When the pin is low, both operands are plain unsigned integers. When it is high, both are two's-complement numbers. The same adder array serves both modes: no second datapath and no multiplexer sit in front of it.

The block is purely combinational and has no clock or reset. The product follows the operands after the array's settling time. The array is built from rows of full adders. Each row adds one partial-product row into a running sum, and its carry ripples across the row. There is no recoding and no tree compression.

Signed mode uses a Baugh-Wooley style correction, so no sign extension is needed. Two groups of partial-product bits are inverted: those that pair one operand's sign bit with a non-sign bit of the other operand. A constant one is then injected at weight 2^W. The constant at weight 2^(2W-1) is applied by flipping the top product bit. The operand width is a parameter: the default of 8 gives an 8x8 to 16-bit unit, and smaller instances allow exhaustive checking.

Top module: `arr_mul`

## Requirements
- R1: The product port is 2*W bits wide and depends only on the present operand and mode values; with no clock, a change at the inputs shows at the product within the same time step.
- R2: With `is_signed` = 0, `prod` equals the unsigned product of `op_a` and `op_b` for every operand pair.
- R3: With `is_signed` = 1, `prod`, read as a 2*W-bit two's-complement value, equals the product of `op_a` and `op_b`, each read as a W-bit two's-complement value.
- R4: The unsigned extreme holds: for W = 8, 255 x 255 gives 65025 (0xFE01).
- R5: The signed extremes hold: for W = 8, -128 x -128 gives +16384 (0x4000), and -128 x 127 gives -16256 (0xC080).
- R6: If either operand is zero, `prod` is zero in both modes.
- R7: When the most significant bit (bit W-1) of both operands is 0, `prod` is the same in both modes.
- R8: In signed mode with both operands nonzero, the product's top bit (bit 2W-1) equals the XOR of the two operands' top bits (bit W-1).
- R9: The parameter W selects the operand width, and R2 and R3 hold for every operand pair at W = 4 as well as at the default W = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Multiplier operand |
| op_b | input | W | Multiplicand operand |
| is_signed | input | 1 | 0: both operands unsigned; 1: both two's-complement |
| prod | output | 2*W | Product |

## Verification
The bench sweeps every operand pair in both modes at W = 8 and at W = 4, and compares each product with a value computed by integer arithmetic.

It checks the following cases by name, and each one catches a particular kind of error:
- The two most negative operands, where a missing or misplaced correction constant gives a negative or wildly wrong product.
- Mixed-sign pairs, where an inversion applied to the wrong bits of the sign row or the sign column shows as an error.
- All-ones unsigned operands, where a dropped carry out of the last row loses the top bits.
- Zero operands and operands whose top bits are clear, where a signed-mode correction that leaks into those cases, or into unsigned mode, gives a nonzero or mode-dependent result.

// File: rtl/arr_mul_pkg.sv
package arr_mul_pkg;

  // Baugh-Wooley style inversion of a partial-product bit in signed mode:
  // flip the bit exactly when one of its two factors is a sign bit.
  function automatic logic bw_flip(input int row, input int col, input int w);
    return ((row == w - 1) != (col == w - 1));
  endfunction

endpackage

// File: rtl/arr_mul_fa.sv
module arr_mul_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  logic hx;

  assign hx = x ^ y;
  assign s  = hx ^ ci;
  assign co = (x & y) | (hx & ci);

endmodule

// File: rtl/arr_mul_pp_row.sv
module arr_mul_pp_row #(
  parameter int W   = 8,
  parameter int ROW = 0
) (
  input  logic [W-1:0] a,
  input  logic         b_bit,
  input  logic         sgn,
  output logic [W-1:0] pp
);

  import arr_mul_pkg::*;

  for (genvar j = 0; j < W; j++) begin : g_col
    localparam bit FLIP = bw_flip(ROW, j, W);
    if (FLIP) begin : g_inv
      assign pp[j] = (a[j] & b_bit) ^ sgn;
    end else begin : g_plain
      assign pp[j] = a[j] & b_bit;
    end
  end

endmodule

// File: rtl/arr_mul_row.sv
module arr_mul_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] c;

  assign c[0] = cin;

  for (genvar k = 0; k < W; k++) begin : g_bit
    arr_mul_fa u_fa (
      .x (x[k]),
      .y (y[k]),
      .ci(c[k]),
      .s (sum[k]),
      .co(c[k+1])
    );
  end

  assign cout = c[W];

endmodule

// File: rtl/arr_mul.sv
module arr_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           is_signed,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [W-1:0] pp     [W];
  logic [W:0]   acc    [W];
  logic [W-1:0] row_s  [W];
  logic         row_co [W];

  // partial-product generation, one row per multiplicand bit
  for (genvar i = 0; i < W; i++) begin : g_pp
    arr_mul_pp_row #(.W(W), .ROW(i)) u_pp (
      .a    (op_a),
      .b_bit(op_b[i]),
      .sgn  (is_signed),
      .pp   (pp[i])
    );
  end

  // first running sum: row 0 plus the signed-mode constant at weight 2^W
  assign acc[0]    = {is_signed, pp[0]};
  assign row_s[0]  = '0;
  assign row_co[0] = 1'b0;

  // ripple-carry accumulation rows
  for (genvar i = 1; i < W; i++) begin : g_row
    arr_mul_row #(.W(W)) u_row (
      .x   (acc[i-1][W:1]),
      .y   (pp[i]),
      .cin (1'b0),
      .sum (row_s[i]),
      .cout(row_co[i])
    );
    assign acc[i] = {row_co[i], row_s[i]};
  end

  // low product bits leave the array one per row
  for (genvar i = 0; i < W - 1; i++) begin : g_low
    assign prod[i] = acc[i][0];
  end

  // top bits come from the last row; weight 2^(2W-1) constant flips the MSB
  assign prod[PW-2:W-1] = acc[W-1][W-1:0];
  assign prod[PW-1]     = acc[W-1][W] ^ is_signed;

endmodule

// File: rtl/arr_mul_chk.sv
module arr_mul_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           is_signed,
  input logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [PW-1:0] ref_u;
  logic [PW-1:0] ref_s;
  logic          both_nz;

  assign ref_u   = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
  assign ref_s   = PW'($signed({{W{op_a[W-1]}}, op_a}) * $signed({{W{op_b[W-1]}}, op_b}));
  assign both_nz = (op_a != '0) && (op_b != '0);

  always_comb begin
    if (!is_signed) AST_UNSIGNED_MATCH: assert (prod == ref_u); // R2
    if (is_signed) AST_SIGNED_MATCH: assert (prod == ref_s); // R3
    if (op_a == '0 || op_b == '0) AST_ZERO_OPERAND: assert (prod == '0); // R6
    if (!op_a[W-1] && !op_b[W-1]) AST_MODE_NEUTRAL: assert (prod == ref_u); // R7
    if (is_signed && both_nz) AST_RESULT_SIGN: assert (prod[PW-1] == (op_a[W-1] ^ op_b[W-1])); // R8
  end

endmodule

bind arr_mul arr_mul_chk #(.W(W)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .is_signed(is_signed),
  .prod     (prod)
);

// File: tb/tb_arr_mul.sv
module tb_arr_mul;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [7:0]  a8, b8;
  logic        s8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic        s4;
  logic [7:0]  p4;

  arr_mul #(.W(8)) dut (.op_a(a8), .op_b(b8), .is_signed(s8), .prod(p8));
  arr_mul #(.W(4)) dut_w4 (.op_a(a4), .op_b(b4), .is_signed(s4), .prod(p4));

  function automatic int expect_p(input int a, input int b, input bit sgn, input int w);
    int sa = a;
    int sb = b;
    if (sgn && a >= (1 << (w - 1))) sa = a - (1 << w);
    if (sgn && b >= (1 << (w - 1))) sb = b - (1 << w);
    return (sa * sb) & ((1 << (2 * w)) - 1);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    a8 = 0; b8 = 0; s8 = 0;
    a4 = 0; b4 = 0; s4 = 0;
    #1;
    check("R6 initial zero operands", int'(p8), 0);

    // R1: product follows a change of inputs without any clock edge
    a8 = 8'd12; b8 = 8'd11; #1;
    check("R1 immediate response", int'(p8), 132);
    a8 = 8'd200; #1;
    check("R1 immediate response after change", int'(p8), 2200);

    // R4 and R5 named extremes
    s8 = 0; a8 = 8'd255; b8 = 8'd255; #1;
    check("R4 255x255 unsigned", int'(p8), 65025);
    s8 = 1; a8 = 8'h80; b8 = 8'h80; #1;
    check("R5 -128x-128 signed", int'(p8), 16384);
    a8 = 8'h80; b8 = 8'h7F; #1;
    check("R5 -128x127 signed", int'(p8), 16'hC080);
    a8 = 8'hFF; b8 = 8'hFF; #1;
    check("R3 -1x-1 signed", int'(p8), 1);

    // R2 / R3 exhaustive at W = 8, with R6 and R8 tagged on the relevant pairs
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          s8 = m[0]; a8 = a[7:0]; b8 = b[7:0];
          #1;
          if (a == 0 || b == 0) check("R6 zero operand", int'(p8), 0);
          else if (m == 1) check("R3 signed W=8", int'(p8), expect_p(a, b, 1'b1, 8));
          else check("R2 unsigned W=8", int'(p8), expect_p(a, b, 1'b0, 8));
          if (m == 1 && a != 0 && b != 0)
            check("R8 result sign", int'(p8[15]), int'(a8[7] ^ b8[7]));
          #1;
        end
      end
    end

    // R9: exhaustive at W = 4 in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          s4 = m[0]; a4 = a[3:0]; b4 = b[3:0];
          #1;
          check("R9 width 4 product", int'(p4), expect_p(a, b, m[0], 4));
          #1;
        end
      end
    end

    // R7: operands with clear top bits give the same product in both modes
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int pu;
        a4 = a[3:0]; b4 = b[3:0]; s4 = 0;
        #1;
        pu = int'(p4);
        s4 = 1;
        #1;
        check("R7 mode-neutral positive operands", int'(p4), pu);
        #1;
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule